// File: doc/BRIEF.md
# Serial DAC Load and Readback Front End

This block is the digital front end of a serial-input voltage DAC. Everything in it runs on one system clock. The serial clock, the frame select, serial data, the load strobe, the readback enable, the clear input and the sleep input are each passed through a synchronizer and then edge-detected. A 16-bit frame is shifted in MSB first while the frame select is low. When the frame closes, the data field is taken from the word and moved into the DAC holding register and the output code register. The output code register is what drives the converter.

The update mode is picked separately for every frame. The block reads the load strobe at the moment the frame opens. If the strobe is low, the frame updates the registers as soon as it closes. If the strobe is high, the word is parked and moves in later, on a falling edge of the load strobe. The same shift register serves two further uses. It echoes the input for daisy chaining, and it can be loaded from the holding register so that the stored code is shifted back out. The clear input forces the output code to zero and leaves the stored data untouched. The sleep input only raises a flag.

Top module: `sdac_front`

## Requirements
- R1: After synchronous reset, code_o is 0, clear_o is 0, pdown_o is 0 and so_o is 0.
- R2: A frame is 16 bits, MSB first, and one bit is taken on each falling edge of sck_i while fs_n_i is low. With RES=14, code = word[13:0]. With RES=12, code = word[13:2]. All other bits of the word are ignored. The coding is straight binary, so the code equals that field unchanged.
- R3: If upd_n_i is low when fs_n_i falls, a complete frame updates both the holding register and code_o once fs_n_i rises.
- R4: If upd_n_i is high when fs_n_i falls, the close of the frame leaves code_o and the holding register unchanged. The word is loaded into both on the next falling edge of upd_n_i.
- R5: A frame that closes after fewer than 16 falling edges of sck_i is discarded, and no register changes.
- R6: so_o carries the shift register MSB. With readback idle, a bit written on sd_i appears on so_o 16 falling edges of sck_i later.
- R7: While rdb_n_i is low, the first falling edge of sck_i copies the holding register into the shift register. With RES=14 the copy is {2'b00, code}; with RES=12 it is {2'b00, code, 2'b00}. Later falling edges shift this copy out on so_o, MSB first.
- R8: A falling edge of zero_n_i drives code_o to 0 and sets clear_o, and the holding register keeps its value. If upd_n_i is low when zero_n_i rises, code_o reloads from the holding register.
- R9: If upd_n_i is high when zero_n_i rises, code_o stays 0 and clear_o drops. code_o then reloads on the next falling edge of upd_n_i.
- R10: pdown_o follows sleep_i, and sleep_i never changes the holding register or code_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock; idles high and is sampled on its falling edge |
| fs_n_i | input | 1 | Frame select, active low |
| sd_i | input | 1 | Serial data in |
| upd_n_i | input | 1 | Load strobe / update-mode select, active low |
| rdb_n_i | input | 1 | Readback enable, active low |
| zero_n_i | input | 1 | Clear-to-ground, active low |
| sleep_i | input | 1 | Power-down request, active high |
| code_o | output | RES | Active output code |
| clear_o | output | 1 | Clear in force |
| pdown_o | output | 1 | Power-down flag |
| so_o | output | 1 | Serial data out |

## Verification
The assertions assume that every serial input is slow compared with the system clock. Each level must stay put for several system cycles, so that after synchronization a clock fall, a frame edge, a clear edge and a load-strobe edge never fall in the same cycle. The stimulus keeps to this in three ways. Every level is held for at least four system cycles. The load strobe and readback enable are set before the frame or serial clock that depends on them. No frame is ever sent while a clear edge or a readback is in progress.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int WORD_W  = 16;
    localparam int MAX_RES = WORD_W - 2;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    typedef enum logic {
        UPD_SYNC  = 1'b0,
        UPD_DEFER = 1'b1
    } upd_mode_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        upd_mode_e         mode;
    } frame_t;

    // Take the code field out of a received word, right-aligned in MAX_RES bits.
    function automatic logic [MAX_RES-1:0] field_of(input logic [WORD_W-1:0] w, input int res);
        logic [MAX_RES-1:0] f;
        if (res == MAX_RES) f = w[MAX_RES-1:0];
        else                f = {2'b00, w[MAX_RES-1:2]};
        return f;
    endfunction

    // Place a code in a readback word, using the same bit layout as a write.
    function automatic logic [WORD_W-1:0] pack_code(input logic [MAX_RES-1:0] c, input int res);
        logic [WORD_W-1:0] w;
        if (res == MAX_RES) w = {2'b00, c};
        else                w = {2'b00, c[MAX_RES-3:0], 2'b00};
        return w;
    endfunction

endpackage

// File: rtl/sdac_sync_edge.sv
module sdac_sync_edge #(
    parameter int           N      = 7,
    parameter int           STAGES = 2,
    parameter logic [N-1:0] IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] pipe;
        logic              last;

        always_ff @(posedge clk) begin
            if (rst) begin
                pipe <= {STAGES{IDLE[g]}};
                last <= IDLE[g];
            end else begin
                pipe <= {pipe[STAGES-2:0], din[g]};
                last <= pipe[STAGES-1];
            end
        end

        assign lvl[g]  = last;
        assign rise[g] = pipe[STAGES-1] & ~last;
        assign fall[g] = ~pipe[STAGES-1] & last;
    end

endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_fall,
    input  logic              fs_fall,
    input  logic              fs_rise,
    input  logic              sd_lvl,
    input  logic              upd_lvl,
    input  logic              rdb_lvl,
    input  logic [WORD_W-1:0] rb_word,
    output frame_t            frame_o,
    output logic              frame_ok_o,
    output logic              so_o
);

    logic [WORD_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              active_q;
    logic              rb_done_q;
    upd_mode_e         mode_q;
    logic              rb_load;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    assign rb_load = sck_fall && !rdb_lvl && !rb_done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q       <= '0;
            cnt_q      <= '0;
            active_q   <= 1'b0;
            rb_done_q  <= 1'b0;
            mode_q     <= UPD_SYNC;
            frame_ok_o <= 1'b0;
        end else begin
            frame_ok_o <= 1'b0;
            if (fs_fall) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
                mode_q   <= upd_lvl ? UPD_DEFER : UPD_SYNC;
            end else if (fs_rise) begin
                active_q <= 1'b0;
                if (active_q && cnt_q == FULL) frame_ok_o <= 1'b1;
            end
            if (rb_load) begin
                sr_q      <= rb_word;
                rb_done_q <= 1'b1;
            end else if (sck_fall && (active_q || !rdb_lvl)) begin
                sr_q <= {sr_q[WORD_W-2:0], sd_lvl};
                if (active_q && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
            end
            if (rdb_lvl) rb_done_q <= 1'b0;
        end
    end

    assign frame_o.word = sr_q;
    assign frame_o.mode = mode_q;
    assign so_o         = sr_q[WORD_W-1];

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

    // R5
    short_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (fs_rise && !fs_fall && cnt_q != FULL) |=> !frame_ok_o);

    // R7
    rb_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rb_load |=> (sr_q[WORD_W-1:WORD_W-2] == 2'b00));

endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
    import sdac_pkg::*;
#(
    parameter int RES = 14
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           frame_ok,
    input  frame_t         frame,
    input  logic           upd_fall,
    input  logic           upd_lvl,
    input  logic           zero_fall,
    input  logic           zero_rise,
    input  logic           zero_lvl,
    output logic [RES-1:0] code_o,
    output logic [RES-1:0] dac_o
);

    logic [MAX_RES-1:0] f_full;
    logic [RES-1:0]     field;
    logic [RES-1:0]     dac_q, pend_q, out_q;
    logic               pend_v_q;
    logic               unused_frame;

    assign f_full       = field_of(frame.word, RES);
    assign field        = f_full[RES-1:0];
    assign unused_frame = ^{frame.word, f_full};

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_q    <= '0;
            pend_q   <= '0;
            out_q    <= '0;
            pend_v_q <= 1'b0;
        end else begin
            if (frame_ok) begin
                if (frame.mode == UPD_SYNC) begin
                    dac_q    <= field;
                    pend_v_q <= 1'b0;
                    if (zero_lvl) out_q <= field;
                end else begin
                    pend_q   <= field;
                    pend_v_q <= 1'b1;
                end
            end else if (upd_fall) begin
                if (pend_v_q) begin
                    dac_q    <= pend_q;
                    pend_v_q <= 1'b0;
                end
                if (zero_lvl) out_q <= pend_v_q ? pend_q : dac_q;
            end
            if (zero_fall)                   out_q <= '0;
            else if (zero_rise && !upd_lvl)  out_q <= dac_q;
        end
    end

    assign code_o = out_q;
    assign dac_o  = dac_q;

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !zero_lvl |-> (out_q == '0));

    // R3
    sync_load_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_ok && frame.mode == UPD_SYNC && zero_lvl && !zero_fall) |=> (out_q == $past(field)));

    // R4
    defer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_ok && frame.mode == UPD_DEFER) |=> $stable(dac_q));

    // R8
    clear_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_fall && !frame_ok && !upd_fall) |=> $stable(dac_q));

endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int RES         = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sck_i,
    input  logic           fs_n_i,
    input  logic           sd_i,
    input  logic           upd_n_i,
    input  logic           rdb_n_i,
    input  logic           zero_n_i,
    input  logic           sleep_i,
    output logic [RES-1:0] code_o,
    output logic           clear_o,
    output logic           pdown_o,
    output logic           so_o
);

    localparam int N_IN  = 7;
    localparam int I_SCK = 0;
    localparam int I_FS  = 1;
    localparam int I_SD  = 2;
    localparam int I_UPD = 3;
    localparam int I_RDB = 4;
    localparam int I_ZER = 5;
    localparam int I_SLP = 6;
    localparam logic [N_IN-1:0] IDLE_LVL = 7'b0111011;

    if (RES != 12 && RES != MAX_RES) begin : g_bad_res
        $error("sdac_front: RES must be 12 or 14");
    end

    logic [N_IN-1:0]    raw, lvl, rise, fall;
    frame_t             frame;
    logic               frame_ok;
    logic [RES-1:0]     dac;
    logic [MAX_RES-1:0] dac_ext;
    logic [WORD_W-1:0]  rb_word;
    logic               unused_evt;

    assign raw = {sleep_i, zero_n_i, rdb_n_i, upd_n_i, sd_i, fs_n_i, sck_i};

    sdac_sync_edge #(
        .N      (N_IN),
        .STAGES (SYNC_STAGES),
        .IDLE   (IDLE_LVL)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    always_comb begin
        dac_ext          = '0;
        dac_ext[RES-1:0] = dac;
    end
    assign rb_word = pack_code(dac_ext, RES);

    sdac_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .sck_fall   (fall[I_SCK]),
        .fs_fall    (fall[I_FS]),
        .fs_rise    (rise[I_FS]),
        .sd_lvl     (lvl[I_SD]),
        .upd_lvl    (lvl[I_UPD]),
        .rdb_lvl    (lvl[I_RDB]),
        .rb_word    (rb_word),
        .frame_o    (frame),
        .frame_ok_o (frame_ok),
        .so_o       (so_o)
    );

    sdac_regs #(.RES(RES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .frame_ok  (frame_ok),
        .frame     (frame),
        .upd_fall  (fall[I_UPD]),
        .upd_lvl   (lvl[I_UPD]),
        .zero_fall (fall[I_ZER]),
        .zero_rise (rise[I_ZER]),
        .zero_lvl  (lvl[I_ZER]),
        .code_o    (code_o),
        .dac_o     (dac)
    );

    assign clear_o = ~lvl[I_ZER];
    assign pdown_o = lvl[I_SLP];

    assign unused_evt = ^{rise[I_SCK], rise[I_SD], rise[I_UPD], rise[I_RDB], rise[I_SLP],
                          fall[I_SD], fall[I_RDB], fall[I_SLP], lvl[I_SCK], lvl[I_FS]};

    // R10
    sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(pdown_o) && !frame_ok && !fall[I_UPD] && !fall[I_ZER] && !rise[I_ZER]) |=> $stable(dac));

endmodule

// File: tb/tb_sdac_front.sv
module tb_sdac_front;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b1, fs_n = 1'b1, sd = 1'b0, upd_n = 1'b0, rdb_n = 1'b1, zero_n = 1'b1, sleep = 1'b0;
    logic [13:0] code14;
    logic [11:0] code12;
    logic clr14, pd14, so14, clr12, pd12, so12;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdac_front #(.RES(14)) dut (
        .clk(clk), .rst(rst), .sck_i(sck), .fs_n_i(fs_n), .sd_i(sd), .upd_n_i(upd_n),
        .rdb_n_i(rdb_n), .zero_n_i(zero_n), .sleep_i(sleep),
        .code_o(code14), .clear_o(clr14), .pdown_o(pd14), .so_o(so14)
    );

    sdac_front #(.RES(12)) dut12 (
        .clk(clk), .rst(rst), .sck_i(sck), .fs_n_i(fs_n), .sd_i(sd), .upd_n_i(upd_n),
        .rdb_n_i(rdb_n), .zero_n_i(zero_n), .sleep_i(sleep),
        .code_o(code12), .clear_o(clr12), .pdown_o(pd12), .so_o(so12)
    );

    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{16'hFFFF, 16'h0000, 16'hC000, 16'h2001,
                                         16'h1555, 16'h3FFE, 16'h8003, 16'h4ABC};

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial clock pulse; the outputs are sampled just before the falling edge.
    task automatic pulse(input logic b, output logic s14, output logic s12);
        sd = b;
        cyc(4);
        s14 = so14;
        s12 = so12;
        sck = 1'b0;
        cyc(4);
        sck = 1'b1;
    endtask

    task automatic send(input logic [15:0] w, input int nbits, input logic upd_lvl,
                        output logic [15:0] cap14);
        logic s14, s12;
        cap14 = '0;
        upd_n = upd_lvl;
        cyc(4);
        fs_n = 1'b0;
        cyc(4);
        for (int i = 0; i < nbits; i++) begin
            pulse(w[15-i], s14, s12);
            cap14 = {cap14[14:0], s14};
        end
        fs_n = 1'b1;
        cyc(10);
    endtask

    task automatic readback(output logic [15:0] r14, output logic [15:0] r12);
        logic s14, s12;
        r14 = '0;
        r12 = '0;
        rdb_n = 1'b0;
        cyc(4);
        pulse(1'b0, s14, s12);
        for (int i = 0; i < 16; i++) begin
            pulse(1'b0, s14, s12);
            r14 = {r14[14:0], s14};
            r12 = {r12[14:0], s12};
        end
        rdb_n = 1'b1;
        cyc(6);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] cap, r14, r12;
        cyc(4);
        // R1 reset state
        chk(code14 == 0, "R1 code", 16'(code14), 16'h0);
        chk(clr14 == 0 && pd14 == 0, "R1 flags", {14'h0, clr14, pd14}, 16'h0);
        chk(so14 == 0, "R1 so", 16'(so14), 16'h0);
        rst = 1'b0;
        cyc(6);

        // R2 and R3: table walk, synchronous mode, both resolutions
        for (int v = 0; v < NV; v++) begin
            send(VEC[v], 16, 1'b0, cap);
            chk(code14 == VEC[v][13:0], "R2/R3 code14", 16'(code14), 16'(VEC[v][13:0]));
            chk(code12 == VEC[v][13:2], "R2 code12", 16'(code12), 16'(VEC[v][13:2]));
        end

        // R6: second frame echoes the first on so
        send(16'hA5C3, 16, 1'b0, cap);
        send(16'h1234, 16, 1'b0, cap);
        chk(cap == 16'hA5C3, "R6 echo", cap, 16'hA5C3);
        chk(code14 == 14'h1234, "R3 code", 16'(code14), 16'h1234);

        // R4: deferred load
        send(16'h0F0F, 16, 1'b1, cap);
        chk(code14 == 14'h1234, "R4 hold at close", 16'(code14), 16'h1234);
        upd_n = 1'b0;
        cyc(10);
        chk(code14 == 14'h0F0F, "R4 load on strobe", 16'(code14), 16'h0F0F);

        // R5: short frame dropped
        send(16'h3333, 10, 1'b0, cap);
        chk(code14 == 14'h0F0F, "R5 short frame", 16'(code14), 16'h0F0F);

        // R7: readback both widths
        readback(r14, r12);
        chk(r14 == 16'h0F0F, "R7 readback14", r14, 16'h0F0F);
        chk(r12 == 16'h0F0C, "R7 readback12", r12, 16'h0F0C);

        // R8: clear with auto reload
        zero_n = 1'b0;
        cyc(10);
        chk(code14 == 0, "R8 clear code", 16'(code14), 16'h0);
        chk(clr14 == 1, "R8 clear flag", 16'(clr14), 16'h1);
        readback(r14, r12);
        chk(r14 == 16'h0F0F, "R8 register kept", r14, 16'h0F0F);
        zero_n = 1'b1;
        cyc(10);
        chk(code14 == 14'h0F0F, "R8 auto reload", 16'(code14), 16'h0F0F);

        // R9: release with strobe high
        upd_n = 1'b1;
        cyc(6);
        zero_n = 1'b0;
        cyc(10);
        zero_n = 1'b1;
        cyc(10);
        chk(code14 == 0, "R9 stays zero", 16'(code14), 16'h0);
        chk(clr14 == 0, "R9 flag drops", 16'(clr14), 16'h0);
        upd_n = 1'b0;
        cyc(10);
        chk(code14 == 14'h0F0F, "R9 reload on strobe", 16'(code14), 16'h0F0F);

        // R10: sleep flag only
        sleep = 1'b1;
        cyc(10);
        chk(pd14 == 1 && pd12 == 1, "R10 flag", {14'h0, pd14, pd12}, 16'h3);
        chk(code14 == 14'h0F0F, "R10 code kept", 16'(code14), 16'h0F0F);
        readback(r14, r12);
        chk(r14 == 16'h0F0F, "R10 register kept", r14, 16'h0F0F);
        sleep = 1'b0;
        cyc(10);
        chk(pd14 == 0, "R10 flag off", 16'(pd14), 16'h0);

        // R1: reset in mid-run
        rst = 1'b1;
        cyc(3);
        chk(code14 == 0 && code12 == 0, "R1 re-reset", 16'(code14), 16'h0);
        rst = 1'b0;
        cyc(4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule